// File: doc/BRIEF.md
# Dual-Register Programmable Logic Cell

This block is one output cell of a sum-of-products logic fabric. It receives the sum terms built by the product array, two per cell by default, and holds one register per sum term. Configuration bits set each register's type (data-load or toggle) and its clock source (its own clock term or the shared clock pin). They also set whether the pad shows a combinational sum or the first register, whether the sum terms are merged, and whether the pad value is inverted. Every register output and the raw pad level go back to the array, so a register can stay buried while the pad serves as an input.

The cell runs on one core clock. The selected clock source of each register is sampled on every core clock edge, and the register updates on the core edge at which that source is first seen high. A per-register clear term empties its register and masks its feedback in the same cycle. A shared preset term sets any register that sees a clock event. A preload path lets a test sequence write the pad level into a chosen register.

Top module: `dual_reg_logic_cell`

## Requirements
- R1: While `rst_n` is low, every register reads 0 on `fb_reg`. In registered mode the pad then shows 0 XOR `cfg_invert`.
- R2: With `cfg_toggle[i]`=0, a clock event on register i loads its data input. The data input is `sum_term[i]`, except for register 0 in merged mode (see R10).
- R3: With `cfg_toggle[i]`=1, a clock event inverts register i when its data input is 1 and keeps it when the data input is 0.
- R4: `cfg_pin_clk[i]`=1 clocks register i from `clk_pin`, and 0 clocks it from `clk_term[i]`. The unselected source has no effect. With no event on its selected source, a register keeps its value.
- R5: `clr_term[i]` high drives `fb_reg[i]` to 0 in the same cycle and empties the register. It overrides preload, preset and clock events.
- R6: `preset_term` high at a clock event of register i sets that register to 1, overriding the data or toggle input. It has no effect on a register without a clock event.
- R7: With `preload_en` high, a clock event of register `preload_sel` (0 selects register 0, 1 selects register 1) stores `pad_in` unaltered, whatever `cfg_invert` is. Preload overrides preset, and registers not selected behave normally.
- R8: `pad_oe` equals `oe_term` at all times.
- R9: `cfg_registered`=1 drives the pad from register 0. With `cfg_registered`=0 the pad is driven from the combinational sum.
- R10: `cfg_merge`=1 ORs all sum terms to form both the combinational pad source and register 0's data input. `cfg_merge`=0 uses `sum_term[0]` alone for both.
- R11: `pad_out` is the selected source XOR `cfg_invert`. The inversion never reaches `fb_reg`.
- R12: `fb_pad` equals `pad_in` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| sum_term | input | NUM_REGS | Sum terms from the array, one per register |
| clk_term | input | NUM_REGS | Per-register clock product terms |
| clr_term | input | NUM_REGS | Per-register clear terms, active high |
| clk_pin | input | 1 | Shared clock pin |
| preset_term | input | 1 | Shared synchronous preset |
| oe_term | input | 1 | Pad output-enable term |
| preload_en | input | 1 | Preload mode |
| preload_sel | input | SELW | Register chosen for preload |
| pad_in | input | 1 | Level seen on the pad |
| cfg_toggle | input | NUM_REGS | 1: toggle register, 0: data register |
| cfg_pin_clk | input | NUM_REGS | 1: clock from pin, 0: from own term |
| cfg_registered | input | 1 | 1: pad from register 0, 0: combinational |
| cfg_merge | input | 1 | 1: OR all sum terms for the pad path |
| cfg_invert | input | 1 | Pad polarity inversion |
| pad_out | output | 1 | Pad data |
| pad_oe | output | 1 | Pad drive enable |
| fb_reg | output | NUM_REGS | Register feedback to the array |
| fb_pad | output | 1 | Pad feedback to the array |

## Verification
A clock event raised between core edges takes effect at the next core edge. The new register value is therefore due one rising edge after the clock term or pin goes high. The bench raises clock sources on a falling edge and samples at the following falling edge, then lowers the source. The clear term, the output-enable term, the combinational pad path and `fb_pad` act within the same cycle. They are sampled one time unit after the stimulus changes, before any rising edge can intervene.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    // State of one register slice: stored bit and last sampled clock source
    typedef struct packed {
        logic q;
        logic clk_prev;
    } slice_state_t;

    // Next-state decision made for one slice in a given cycle
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_PRELOAD,
        ACT_PRESET,
        ACT_LOAD,
        ACT_TOGGLE
    } slice_act_e;

endpackage

// File: rtl/dlc_reg_slice.sv
module dlc_reg_slice
    import dlc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    input  logic toggle_mode,
    input  logic pin_clk_sel,
    input  logic clk_term,
    input  logic clk_pin,
    input  logic clr,
    input  logic preset,
    input  logic preload_hit,
    input  logic preload_data,
    output logic q_out
);

    slice_state_t st_d, st_q;
    slice_act_e   act;
    logic         clk_src;
    logic         clk_event;

    always_comb begin
        clk_src   = pin_clk_sel ? clk_pin : clk_term;
        clk_event = clk_src & ~st_q.clk_prev;

        if (clr)              act = ACT_CLEAR;
        else if (!clk_event)  act = ACT_HOLD;
        else if (preload_hit) act = ACT_PRELOAD;
        else if (preset)      act = ACT_PRESET;
        else if (toggle_mode) act = ACT_TOGGLE;
        else                  act = ACT_LOAD;

        st_d          = st_q;
        st_d.clk_prev = clk_src;
        case (act)
            ACT_CLEAR:   st_d.q = 1'b0;
            ACT_PRELOAD: st_d.q = preload_data;
            ACT_PRESET:  st_d.q = 1'b1;
            ACT_TOGGLE:  st_d.q = st_q.q ^ d_in;
            ACT_LOAD:    st_d.q = d_in;
            default:     st_d.q = st_q.q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Clear masks the feedback in the same cycle it rises
    assign q_out = st_q.q & ~clr;

endmodule

// File: rtl/dlc_out_path.sv
module dlc_out_path #(
    parameter int NUM_REGS = 2
) (
    input  logic [NUM_REGS-1:0] sum_term,
    input  logic                reg_q,
    input  logic                cfg_registered,
    input  logic                cfg_merge,
    input  logic                cfg_invert,
    input  logic                oe_term,
    output logic                merged_sum,
    output logic                pad_out,
    output logic                pad_oe
);

    logic comb_src;
    logic sel_src;

    always_comb begin
        merged_sum = |sum_term;
        comb_src   = cfg_merge ? merged_sum : sum_term[0];
        sel_src    = cfg_registered ? reg_q : comb_src;
        pad_out    = sel_src ^ cfg_invert;
        pad_oe     = oe_term;
    end

endmodule

// File: rtl/dual_reg_logic_cell.sv
module dual_reg_logic_cell #(
    parameter int NUM_REGS = 2,
    localparam int SELW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] sum_term,
    input  logic [NUM_REGS-1:0] clk_term,
    input  logic [NUM_REGS-1:0] clr_term,
    input  logic                clk_pin,
    input  logic                preset_term,
    input  logic                oe_term,
    input  logic                preload_en,
    input  logic [SELW-1:0]     preload_sel,
    input  logic                pad_in,
    input  logic [NUM_REGS-1:0] cfg_toggle,
    input  logic [NUM_REGS-1:0] cfg_pin_clk,
    input  logic                cfg_registered,
    input  logic                cfg_merge,
    input  logic                cfg_invert,
    output logic                pad_out,
    output logic                pad_oe,
    output logic [NUM_REGS-1:0] fb_reg,
    output logic                fb_pad
);

    logic                merged_sum;
    logic [NUM_REGS-1:0] d_vec;
    logic [NUM_REGS-1:0] pl_hit;

    dlc_out_path #(.NUM_REGS(NUM_REGS)) u_out (
        .sum_term       (sum_term),
        .reg_q          (fb_reg[0]),
        .cfg_registered (cfg_registered),
        .cfg_merge      (cfg_merge),
        .cfg_invert     (cfg_invert),
        .oe_term        (oe_term),
        .merged_sum     (merged_sum),
        .pad_out        (pad_out),
        .pad_oe         (pad_oe)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slice
        if (i == 0) begin : g_first
            assign d_vec[i] = cfg_merge ? merged_sum : sum_term[i];
        end else begin : g_rest
            assign d_vec[i] = sum_term[i];
        end
        assign pl_hit[i] = preload_en && (preload_sel == SELW'(i));

        dlc_reg_slice u_reg (
            .clk          (clk),
            .rst_n        (rst_n),
            .d_in         (d_vec[i]),
            .toggle_mode  (cfg_toggle[i]),
            .pin_clk_sel  (cfg_pin_clk[i]),
            .clk_term     (clk_term[i]),
            .clk_pin      (clk_pin),
            .clr          (clr_term[i]),
            .preset       (preset_term),
            .preload_hit  (pl_hit[i]),
            .preload_data (pad_in),
            .q_out        (fb_reg[i])
        );
    end

    assign fb_pad = pad_in;

endmodule

// File: rtl/dlc_cell_checker.sv
module dlc_cell_checker #(
    parameter int NUM_REGS = 2,
    localparam int SELW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_REGS-1:0] sum_term,
    input logic [NUM_REGS-1:0] clk_term,
    input logic [NUM_REGS-1:0] clr_term,
    input logic                clk_pin,
    input logic                preset_term,
    input logic                oe_term,
    input logic                preload_en,
    input logic [SELW-1:0]     preload_sel,
    input logic                pad_in,
    input logic [NUM_REGS-1:0] cfg_toggle,
    input logic [NUM_REGS-1:0] cfg_pin_clk,
    input logic                cfg_registered,
    input logic                cfg_merge,
    input logic                cfg_invert,
    input logic                pad_out,
    input logic                pad_oe,
    input logic [NUM_REGS-1:0] fb_reg,
    input logic                fb_pad
);

    logic [NUM_REGS-1:0] src_now, src_seen, evt, dat;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
        assign src_now[i] = cfg_pin_clk[i] ? clk_pin : clk_term[i];
        assign evt[i]     = src_now[i] && !src_seen[i];
        if (i == 0) begin : g_d0
            assign dat[i] = cfg_merge ? (|sum_term) : sum_term[0];
        end else begin : g_dn
            assign dat[i] = sum_term[i];
        end

        // R5: clear masks feedback
        p_clear_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            clr_term[i] |-> !fb_reg[i]);

        // R6: preset sets on a clock event
        p_preset_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && !clr_term[i] && preset_term &&
             !(preload_en && preload_sel == SELW'(i)))
            |=> (fb_reg[i] || clr_term[i]));

        // R3: toggle inverts when data is 1
        p_toggle_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && !clr_term[i] && !preset_term && cfg_toggle[i] && dat[i] &&
             !(preload_en && preload_sel == SELW'(i)))
            |=> ((fb_reg[i] == !$past(fb_reg[i])) || clr_term[i]));

        // R4: no clock event, no change
        p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[i] && !clr_term[i])
            |=> ((fb_reg[i] == $past(fb_reg[i])) || clr_term[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_seen <= '0;
        else        src_seen <= src_now;
    end

    // R8: enable follows its term
    p_oe_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe == oe_term);

    // R11: pad is register 0 with polarity applied
    p_pad_polarity_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_registered |-> (pad_out == (fb_reg[0] ^ cfg_invert)));

    // R12: pad feedback is the raw pad level
    p_pad_feedback_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pad == pad_in);

endmodule

bind dual_reg_logic_cell dlc_cell_checker #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/dual_reg_logic_cell_test.sv
module dual_reg_logic_cell_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sum_term = '0, clk_term = '0, clr_term = '0;
    logic       clk_pin = 1'b0, preset_term = 1'b0, oe_term = 1'b1;
    logic       preload_en = 1'b0;
    logic [0:0] preload_sel = '0;
    logic       pad_in = 1'b0;
    logic [1:0] cfg_toggle = '0, cfg_pin_clk = '0;
    logic       cfg_registered = 1'b1, cfg_merge = 1'b0, cfg_invert = 1'b1;
    logic       pad_out, pad_oe, fb_pad;
    logic [1:0] fb_reg;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dual_reg_logic_cell #(.NUM_REGS(2)) uut (.*);

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Raise clock sources on a falling edge, lower them one cycle later
    task automatic pulse(input logic [1:0] terms, input logic pin);
        @(negedge clk);
        clk_term = terms;
        clk_pin  = pin;
        @(negedge clk);
        clk_term = '0;
        clk_pin  = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_term = 2'b11;
        @(negedge clk);
        clr_term = 2'b00;
    endtask

    task automatic t_reset();
        #5;
        check("R1 regs in reset", {2'b0, fb_reg}, 4'h0);
        check("R1 pad polarity in reset", {3'b0, pad_out}, 4'h1);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 regs after reset", {2'b0, fb_reg}, 4'h0);
    endtask

    task automatic t_data_mode();
        clear_all();
        cfg_toggle = 2'b00; cfg_pin_clk = 2'b00; cfg_merge = 1'b0;
        sum_term = 2'b01;
        pulse(2'b01, 1'b0);
        check("R2 load reg0", {2'b0, fb_reg}, 4'h1);
        sum_term = 2'b10;
        pulse(2'b11, 1'b0);
        check("R2 load both", {2'b0, fb_reg}, 4'h2);
    endtask

    task automatic t_toggle_mode();
        clear_all();
        cfg_toggle = 2'b11;
        sum_term = 2'b11;
        pulse(2'b01, 1'b0);
        check("R3 toggle to 1", {2'b0, fb_reg}, 4'h1);
        sum_term = 2'b00;
        pulse(2'b11, 1'b0);
        check("R3 hold on 0", {2'b0, fb_reg}, 4'h1);
        sum_term = 2'b11;
        pulse(2'b11, 1'b0);
        check("R3 toggle both", {2'b0, fb_reg}, 4'h2);
        cfg_toggle = 2'b00;
    endtask

    task automatic t_clock_select();
        clear_all();
        cfg_pin_clk = 2'b01;
        sum_term = 2'b11;
        pulse(2'b01, 1'b0);
        check("R4 unselected term ignored", {2'b0, fb_reg}, 4'h0);
        pulse(2'b00, 1'b1);
        check("R4 pin clocks reg0 only", {2'b0, fb_reg}, 4'h1);
        pulse(2'b10, 1'b0);
        check("R4 own term clocks reg1", {2'b0, fb_reg}, 4'h3);
        cfg_pin_clk = 2'b00;
    endtask

    task automatic t_clear();
        clear_all();
        sum_term = 2'b11;
        pulse(2'b11, 1'b0);
        check("R5 setup", {2'b0, fb_reg}, 4'h3);
        @(negedge clk);
        clr_term = 2'b01;
        #1;
        check("R5 immediate clear", {2'b0, fb_reg}, 4'h2);
        preset_term = 1'b1;
        pulse(2'b01, 1'b0);
        check("R5 clear beats clock and preset", {2'b0, fb_reg}, 4'h2);
        preset_term = 1'b0;
        clr_term = 2'b00;
        #1;
        check("R5 stays empty after release", {2'b0, fb_reg}, 4'h2);
    endtask

    task automatic t_preset();
        clear_all();
        sum_term = 2'b00;
        preset_term = 1'b1;
        pulse(2'b01, 1'b0);
        check("R6 preset on clocked reg only", {2'b0, fb_reg}, 4'h1);
        cfg_toggle = 2'b01;
        sum_term = 2'b01;
        pulse(2'b01, 1'b0);
        check("R6 preset beats toggle", {2'b0, fb_reg}, 4'h1);
        preset_term = 1'b0;
        cfg_toggle = 2'b00;
    endtask

    task automatic t_preload();
        clear_all();
        cfg_invert = 1'b1;
        preset_term = 1'b1;
        pulse(2'b11, 1'b0);
        check("R7 setup", {2'b0, fb_reg}, 4'h3);
        preload_en = 1'b1; preload_sel = 1'b0; pad_in = 1'b0;
        pulse(2'b11, 1'b0);
        check("R7 sel0 preload beats preset", {2'b0, fb_reg}, 4'h2);
        preset_term = 1'b0;
        sum_term = 2'b11;
        preload_sel = 1'b1; pad_in = 1'b0;
        pulse(2'b10, 1'b0);
        check("R7 sel1 loads pad level", {2'b0, fb_reg}, 4'h0);
        pad_in = 1'b1;
        pulse(2'b11, 1'b0);
        check("R7 raw pad level, reg0 normal", {2'b0, fb_reg}, 4'h3);
        preload_en = 1'b0; pad_in = 1'b0;
    endtask

    task automatic t_output();
        @(negedge clk);
        cfg_registered = 1'b0; cfg_merge = 1'b0; cfg_invert = 1'b0; oe_term = 1'b1;
        sum_term = 2'b10;
        #1;
        check("R10 separate comb source", {3'b0, pad_out}, 4'h0);
        cfg_merge = 1'b1;
        #1;
        check("R10 merged comb source", {3'b0, pad_out}, 4'h1);
        cfg_invert = 1'b1;
        #1;
        check("R11 comb inverted", {3'b0, pad_out}, 4'h0);
        oe_term = 1'b0;
        #1;
        check("R8 enable low", {3'b0, pad_oe}, 4'h0);
        oe_term = 1'b1;
        #1;
        check("R8 enable high", {3'b0, pad_oe}, 4'h1);
        clear_all();
        pulse(2'b01, 1'b0);
        check("R10 merged data into reg0", {2'b0, fb_reg}, 4'h1);
        cfg_registered = 1'b1;
        sum_term = 2'b00;
        #1;
        check("R9 registered source", {3'b0, pad_out}, 4'h0);
        check("R11 feedback not inverted", {2'b0, fb_reg}, 4'h1);
        cfg_invert = 1'b0;
        #1;
        check("R9 registered true polarity", {3'b0, pad_out}, 4'h1);
        cfg_merge = 1'b0;
    endtask

    task automatic t_pad_feedback();
        pad_in = 1'b1;
        #1;
        check("R12 pad high", {3'b0, fb_pad}, 4'h1);
        pad_in = 1'b0;
        #1;
        check("R12 pad low", {3'b0, fb_pad}, 4'h0);
    endtask

    initial begin
        t_reset();
        t_data_mode();
        t_toggle_mode();
        t_clock_select();
        t_clear();
        t_preset();
        t_preload();
        t_output();
        t_pad_feedback();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule